// File: doc/BRIEF.md
# Pulse-Swallow Programmable RF Divider

This block divides a fast input clock by a 15-bit programmable ratio using a dual-modulus prescaler and two counters. The ratio word is split into an upper 11-bit main count M (ratio bits 14..4) and a lower 4-bit swallow count A (ratio bits 3..0), so that the division ratio is N = 16·M + A. Within every output cycle the prescaler first divides by 17 for A of its cycles and then by 16 for the remaining M−A cycles. The result is one output cycle of exactly N input clocks. The divided pulse feeds a phase comparator. A toggling half-rate copy of it is available for observation on a test port.

The ratio input is sampled only at the boundary between output cycles, so a cycle in progress always completes at the length it started with. Ratios below 240 cannot be built, because M would then be smaller than the largest A. Such a ratio is replaced by 240 and flagged for the output cycle that uses it.

The control sits in a small state machine. ST_LOAD is entered from reset; on the next clock it loads the counters and moves to ST_SWALLOW when A is non-zero, otherwise to ST_MAIN. ST_SWALLOW (prescaler at 17) moves to ST_MAIN when its last swallow cycle ends and main cycles remain. If no main cycles remain (M = A), the output cycle ends there. ST_MAIN (prescaler at 16) ends the output cycle when its last main cycle ends. Every output-cycle end reloads the counters and goes straight back to ST_SWALLOW or ST_MAIN, according to the newly sampled A.

Top module: `psw_rf_divider`

## Requirements
- R1: With ratio bits 14..4 taken as M and bits 3..0 as A, consecutive rising pulses on `pulse_o` are exactly 16·M + A input clocks apart.
- R2: `pulse_o` is high for exactly one input clock per output cycle.
- R3: Within each output cycle the prescaler runs A cycles of 17 clocks, then M−A cycles of 16 clocks. The swallow count A therefore adds one clock per unit.
- R4: Every ratio from 240 to 32767 is honoured, including 255 (M equal to A, no divide-by-16 cycles) and 32767.
- R5: A ratio below 240 produces an output cycle of 240 clocks, and `illegal_o` is 1 during that cycle.
- R6: A change of `ratio_i` between output-cycle boundaries has no effect on the cycle in progress. Only the value present at the clock edge that ends a cycle sets the next cycle.
- R7: `div2_o` toggles at the same clock edge at which `pulse_o` rises, and at no other time.
- R8: While `rst_i` is high, `pulse_o`, `div2_o` and `illegal_o` are 0. The first clock after reset samples the ratio for the first output cycle.
- R9: `illegal_o` changes only at output-cycle boundaries. It returns to 0 for the first cycle whose sampled ratio is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_i | input | 15 | Division ratio; bits 14..4 main count, bits 3..0 swallow count |
| pulse_o | output | 1 | One-clock pulse at the end of each output cycle |
| div2_o | output | 1 | Divided output halved (toggles once per output cycle) |
| illegal_o | output | 1 | Current output cycle uses a clamped ratio |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of an output cycle. It must still leave that cycle's length untouched, and a short-lived illegal value must never raise the flag. The bench therefore writes several ratios, one of them illegal, at arbitrary clocks between two pulses. It then measures the interval in progress against the ratio held at the previous boundary. Separately, it sweeps every swallow value for small main counts, including the single ratio with no divide-by-16 cycles, and covers the largest ratio.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psw_state_e;

endpackage

// File: rtl/psw_ratio_gate.sv
// Splits the ratio word into main and swallow fields, clamps illegal
// values to the minimum ratio and keeps the per-cycle illegal flag.
module psw_ratio_gate #(
    parameter int A_W       = 4,
    parameter int M_W       = 11,
    parameter int MIN_RATIO = 240,
    localparam int R_W      = A_W + M_W
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           commit_i,
    input  logic [R_W-1:0] ratio_i,
    output logic [M_W-1:0] eff_m_o,
    output logic [A_W-1:0] eff_a_o,
    output logic           illegal_o
);

    localparam logic [R_W-1:0] MIN_WORD = R_W'(MIN_RATIO);

    logic           below;
    logic [R_W-1:0] eff_word;

    always_comb begin
        below    = (ratio_i < MIN_WORD);
        eff_word = below ? MIN_WORD : ratio_i;
        eff_m_o  = eff_word[R_W-1:A_W];
        eff_a_o  = eff_word[A_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            illegal_o <= 1'b0;
        end else if (commit_i) begin
            illegal_o <= below;
        end
    end

endmodule

// File: rtl/psw_prescaler.sv
// Dual-modulus prescaler: divides by 2**A_W or 2**A_W + 1.
module psw_prescaler #(
    parameter int A_W = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,
    input  logic mod_hi_i,
    output logic tick_o
);

    localparam int C_W = A_W + 1;
    localparam logic [C_W-1:0] LAST_LO = C_W'((1 << A_W) - 1);
    localparam logic [C_W-1:0] LAST_HI = C_W'(1 << A_W);

    logic [C_W-1:0] cnt_q;
    logic [C_W-1:0] last;

    always_comb begin
        last   = mod_hi_i ? LAST_HI : LAST_LO;
        tick_o = !hold_i && (cnt_q == last);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/psw_swallow_fsm.sv
// Sequences the swallow phase (prescaler high modulus) and the main
// phase (low modulus) of each output cycle and forms the outputs.
module psw_swallow_fsm
    import psw_pkg::*;
#(
    parameter int A_W = 4,
    parameter int M_W = 11
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           tick_i,
    input  logic [M_W-1:0] eff_m_i,
    input  logic [A_W-1:0] eff_a_i,
    output logic           hold_o,
    output logic           mod_hi_o,
    output logic           cycle_end_o,
    output logic [1:0]     state_o,
    output logic           pulse_o,
    output logic           div2_o
);

    psw_state_e     state_q, state_d;
    logic [A_W-1:0] sw_left_q;
    logic [M_W-1:0] mn_left_q;
    logic           reload;
    logic           first_phase_swallow;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and combinational outputs
    always_comb begin
        state_d             = state_q;
        hold_o              = 1'b0;
        mod_hi_o            = 1'b0;
        cycle_end_o         = 1'b0;
        first_phase_swallow = (eff_a_i != '0);
        unique case (state_q)
            ST_LOAD: begin
                hold_o  = 1'b1;
                state_d = first_phase_swallow ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                mod_hi_o = 1'b1;
                if (tick_i && (sw_left_q == A_W'(1))) begin
                    if (mn_left_q == '0) begin
                        cycle_end_o = 1'b1;
                        state_d     = first_phase_swallow ? ST_SWALLOW : ST_MAIN;
                    end else begin
                        state_d = ST_MAIN;
                    end
                end
            end
            ST_MAIN: begin
                if (tick_i && (mn_left_q == M_W'(1))) begin
                    cycle_end_o = 1'b1;
                    state_d     = first_phase_swallow ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
        reload  = (state_q == ST_LOAD) || cycle_end_o;
        state_o = state_q;
    end

    // phase counters
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sw_left_q <= '0;
            mn_left_q <= '0;
        end else if (reload) begin
            sw_left_q <= eff_a_i;
            mn_left_q <= eff_m_i - M_W'(eff_a_i);
        end else if (tick_i) begin
            if (state_q == ST_SWALLOW) begin
                sw_left_q <= sw_left_q - 1'b1;
            end else if (state_q == ST_MAIN) begin
                mn_left_q <= mn_left_q - 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_o <= 1'b0;
            div2_o  <= 1'b0;
        end else begin
            pulse_o <= cycle_end_o;
            div2_o  <= div2_o ^ cycle_end_o;
        end
    end

endmodule

// File: rtl/psw_rf_divider.sv
module psw_rf_divider #(
    parameter int A_W       = 4,
    parameter int M_W       = 11,
    parameter int MIN_RATIO = 240,
    localparam int R_W      = A_W + M_W
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [R_W-1:0] ratio_i,
    output logic           pulse_o,
    output logic           div2_o,
    output logic           illegal_o
);

    logic [M_W-1:0] eff_m;
    logic [A_W-1:0] eff_a;
    logic           pre_tick;
    logic           pre_hold;
    logic           mod_hi;
    logic           cycle_end;
    logic [1:0]     fsm_state;
    logic           commit;

    assign commit = cycle_end || pre_hold;

    psw_ratio_gate #(
        .A_W       (A_W),
        .M_W       (M_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_gate (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .commit_i  (commit),
        .ratio_i   (ratio_i),
        .eff_m_o   (eff_m),
        .eff_a_o   (eff_a),
        .illegal_o (illegal_o)
    );

    psw_prescaler #(
        .A_W (A_W)
    ) u_pre (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .hold_i   (pre_hold),
        .mod_hi_i (mod_hi),
        .tick_o   (pre_tick)
    );

    psw_swallow_fsm #(
        .A_W (A_W),
        .M_W (M_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (pre_tick),
        .eff_m_i     (eff_m),
        .eff_a_i     (eff_a),
        .hold_o      (pre_hold),
        .mod_hi_o    (mod_hi),
        .cycle_end_o (cycle_end),
        .state_o     (fsm_state),
        .pulse_o     (pulse_o),
        .div2_o      (div2_o)
    );

endmodule

// File: rtl/psw_rf_divider_chk.sv
module psw_rf_divider_chk #(
    parameter int A_W       = 4,
    parameter int MIN_RATIO = 240,
    parameter int MAX_RATIO = 32767
) (
    input logic       clk,
    input logic       rst,
    input logic       pulse,
    input logic       div2,
    input logic       illegal,
    input logic       tick,
    input logic       mod_hi,
    input logic [1:0] state_bits
);

    localparam int PW = 16;
    localparam logic [PW-1:0] LEN_LO = PW'((1 << A_W) - 1);
    localparam logic [PW-1:0] LEN_HI = PW'(1 << A_W);

    logic [PW-1:0] pre_cnt;
    logic [PW-1:0] per_cnt;
    logic          seen;
    logic          in_load;

    assign in_load = (state_bits == 2'd0);

    always_ff @(posedge clk) begin
        if (rst || tick || in_load) begin
            pre_cnt <= '0;
        end else if (pre_cnt != '1) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt <= '0;
            seen    <= 1'b0;
        end else if (pulse) begin
            per_cnt <= '0;
            seen    <= 1'b1;
        end else if (per_cnt != '1) begin
            per_cnt <= per_cnt + 1'b1;
        end
    end

    // R3
    prescale_len_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (pre_cnt == (mod_hi ? LEN_HI : LEN_LO)));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R7
    div2_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (div2 != $past(div2)) |-> pulse);

    // R9
    illegal_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal != $past(illegal)) |-> (pulse || $past(in_load)));

    // R5
    period_min_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && seen) |-> (per_cnt >= PW'(MIN_RATIO - 1)));

    // R4
    period_max_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && seen) |-> (per_cnt <= PW'(MAX_RATIO - 1)));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!pulse && !div2 && !illegal));

endmodule

bind psw_rf_divider psw_rf_divider_chk #(
    .A_W       (A_W),
    .MIN_RATIO (MIN_RATIO),
    .MAX_RATIO ((1 << (A_W + M_W)) - 1)
) u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .pulse      (pulse_o),
    .div2       (div2_o),
    .illegal    (illegal_o),
    .tick       (pre_tick),
    .mod_hi     (mod_hi),
    .state_bits (fsm_state)
);

// File: tb/tb_psw_rf_divider.sv
`timescale 1ns/1ps
module tb_psw_rf_divider;

    localparam int MIN_R = 240;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] ratio;
    logic        pulse_o, div2_o, illegal_o;

    int    n_chk = 0, n_bad = 0, cycles = 0, npulse = 0, cnt = 0, exp_len = 0;
    bit    armed = 0, prev_pulse = 0, div2_exp = 0, stopped = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    psw_rf_divider dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .ratio_i   (ratio),
        .pulse_o   (pulse_o),
        .div2_o    (div2_o),
        .illegal_o (illegal_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int eff_ratio(input int r);
        return (r < MIN_R) ? MIN_R : r;
    endfunction

    // one clock: sampled at the falling edge, before any new stimulus
    task automatic step();
        @(negedge clk);
        cycles++;
        if (cycles > LIMIT && !stopped) begin
            stopped = 1;
            check(1'b0, "watchdog", cycles, LIMIT);
            finish_run();
        end
        cnt++;
        if (!rst && pulse_o) begin
            check(!prev_pulse, "R2", 1, 0);
            div2_exp = ~div2_exp;
            check(div2_o == div2_exp, "R7", int'(div2_o), int'(div2_exp));
            if (armed) check(cnt == exp_len, cur_req, cnt, exp_len);
            exp_len = eff_ratio(int'(ratio));
            check(illegal_o == (int'(ratio) < MIN_R),
                  (int'(ratio) < MIN_R) ? "R5" : "R9",
                  int'(illegal_o), int'(int'(ratio) < MIN_R));
            cnt   = 0;
            armed = 1;
            npulse++;
        end else if (!rst) begin
            check(div2_o == div2_exp, "R7", int'(div2_o), int'(div2_exp));
        end
        prev_pulse = pulse_o;
    endtask

    task automatic wait_pulses(input int n);
        int target;
        target = npulse + n;
        while (npulse < target) step();
    endtask

    task automatic run_ratio(input int r, input string req);
        ratio   = 15'(r);
        cur_req = req;
        wait_pulses(2);
    endtask

    initial begin
        rst   = 1'b1;
        ratio = 15'd240;
        for (int i = 0; i < 4; i++) begin
            step();
            check(!pulse_o && !div2_o && !illegal_o, "R8",
                  int'({pulse_o, div2_o, illegal_o}), 0);
        end
        rst = 1'b0;
        cur_req = "R8";
        wait_pulses(2);

        // swallow sweep for small main counts
        foreach (sweep_m[k]) begin
            for (int a = 0; a < 16; a++) begin
                run_ratio(sweep_m[k] * 16 + a, (a == 0) ? "R1" : "R3");
            end
        end

        // range edges
        run_ratio(255, "R4");
        run_ratio(32767, "R4");
        run_ratio(241, "R4");

        // illegal ratios, then recovery
        run_ratio(0, "R5");
        run_ratio(239, "R5");
        run_ratio(17, "R5");
        run_ratio(1000, "R9");

        // mid-cycle changes
        run_ratio(300, "R6");
        repeat (100) step();
        ratio = 15'd5000;
        repeat (50) step();
        ratio = 15'd10;
        repeat (40) step();
        ratio = 15'd700;
        wait_pulses(2);
        run_ratio(400, "R6");
        repeat (10) step();
        ratio = 15'd3;
        repeat (100) step();
        ratio = 15'd262;
        wait_pulses(2);

        finish_run();
    end

    int sweep_m [3] = '{15, 16, 64};

endmodule